// File: doc/BRIEF.md
# Two-Wire Bus Occupancy Monitor with Stuck-Data Recovery

This block watches the data and clock lines of a two-wire bus and keeps a flag that says whether the bus is in use. The flag rises on a Start condition or whenever either line is seen low. It falls on a Stop condition, when the block is disabled, or when software writes 1 to it. Both lines are brought through a synchroniser before any decision is made. Start and Stop are recognised as data-line edges that occur while the clock line is high.

The block also supports recovery when an out-of-step slave holds the data line low. Software can read the synchronised data level at any time. It can then issue a one-shot command that pulls the clock line low for a fixed number of system clocks and releases it for the same number. The command bit reads 1 while this pulse runs and clears itself when the pulse ends. The clock drive is open-drain: the block only pulls the line low or lets it go.

Software sees one 8-bit status/command word. Bit 0 is the busy flag (write 1 to clear). Bit 1 is the synchronised data level (read only). Bit 2 is the recovery-pulse command and status. Bits 7:3 read 0.

Top module: `bus_busy_recover`

## Requirements
- R1: After reset the busy flag and command bit read 0, the clock line is released, and bits 7:3 of `reg_rdata` read 0.
- R2: `reg_rdata[1]` always equals the level of `sda_in` delayed by SYNC_STAGES (default 2) clock edges. A write to that bit has no effect.
- R3: While enabled, the busy flag (`reg_rdata[0]`) is 1 in the cycle after the synchronised data or clock line is low, or after a Start condition, unless a Stop or a clear happens in that cycle.
- R4: A Stop condition (a synchronised data rise while the synchronised clock stays high) clears the busy flag on the next edge.
- R5: A write with `reg_wdata[0]`=1 clears the busy flag. A write with `reg_wdata[0]`=0 leaves it unchanged.
- R6: A write with `reg_wdata[2]`=1 while the synchronised data level is 0 starts a recovery pulse on the next edge. `scl_pull_low` is 1 for exactly PHASE_CYC (default 8) cycles and then 0 for PHASE_CYC cycles. `reg_rdata[2]` reads 1 for all 2*PHASE_CYC cycles and then returns to 0.
- R7: A write with `reg_wdata[2]`=1 while the synchronised data level is 1 starts no pulse.
- R8: A write with `reg_wdata[2]`=1 while a pulse is running neither extends nor restarts it.
- R9: While `enable` is 0, the busy flag and command bit are 0 from the next edge on, `scl_pull_low` is 0, and no command is accepted.
- R10: `scl_pull_low` is never 1 unless `reg_rdata[2]` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; 0 clears the flags and aborts a pulse |
| sda_in | input | 1 | Sampled level of the bus data line (asynchronous) |
| scl_in | input | 1 | Sampled level of the bus clock line (asynchronous) |
| reg_wr | input | 1 | Write strobe for the status/command word |
| reg_wdata | input | 8 | Write data: bit 0 clears busy, bit 2 requests a pulse |
| reg_rdata | output | 8 | Status word: bit 0 busy, bit 1 data level, bit 2 pulse active |
| scl_pull_low | output | 1 | Open-drain clock drive; 1 pulls the clock line low |

## Verification
A wrong busy state can stay hidden while the bus is idle. It shows up one cycle after a line falls or a Stop arrives, so the bench compares the status word against a reference model on every cycle. A phase counter that is off by one shows only in how long `scl_pull_low` stays high and how long bit 2 reads 1. The bench therefore counts whole pulses, including a pulse that receives a second command part-way through. The synchroniser depth shows in the two-cycle lag of bit 1 behind `sda_in`. Because the model drives the clock line as open-drain, a pulse that starts or stops in the wrong cycle also disturbs the busy flag.

// File: rtl/bus_busy_recover_pkg.sv
// Package: shared encodings for the bus occupancy monitor.
// Assumes an 8-bit status/command word; bit positions below are the
// software-visible layout.
package bus_busy_recover_pkg;
    localparam int WORD_W   = 8;
    localparam int BIT_BUSY = 0;   // busy flag, write 1 to clear
    localparam int BIT_SDA  = 1;   // synchronised data level, read only
    localparam int BIT_TGL  = 2;   // recovery pulse command / in progress

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_LOW  = 2'b01,
        PH_HIGH = 2'b10
    } pulse_phase_e;
endpackage

// File: rtl/bbr_line_sync.sv
// Module: multi-stage synchroniser for a group of asynchronous line levels.
// Assumes lines idle high, so every stage resets to 1.
module bbr_line_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // first stage: capture raw line levels
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '1;
                    else        chain[s] <= d_async;
                end
            end else begin : g_rest
                // later stages: settle metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '1;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/bbr_cond_detect.sv
// Module: Start/Stop recogniser on synchronised lines.
// Start = data falls while clock stays high; Stop = data rises while clock
// stays high. Outputs are single-cycle pulses aligned with the new level.
module bbr_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_s,
    input  logic scl_s,
    output logic start_det,
    output logic stop_det
);
    logic sda_prev;
    logic scl_prev;

    // hold previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_prev <= 1'b1;
            scl_prev <= 1'b1;
        end else begin
            sda_prev <= sda_s;
            scl_prev <= scl_s;
        end
    end

    // decode conditions from level pairs
    always_comb begin
        start_det = scl_s & scl_prev & sda_prev & ~sda_s;
        stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
    end
endmodule

// File: rtl/bbr_pulse_gen.sv
// Module: one-shot clock-line pulse generator for stuck-data recovery.
// Accepts a request only when idle, enabled and the data level is low;
// then pulls low for PHASE_CYC cycles and releases for PHASE_CYC cycles.
module bbr_pulse_gen
    import bus_busy_recover_pkg::*;
#(
    parameter int PHASE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cmd_req,
    input  logic sda_lvl,
    output logic pull_low,
    output logic active
);
    localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);
    localparam int RW = $clog2(PHASE_CYC + 2);

    pulse_phase_e    phase;
    logic [CW-1:0]   cnt;

    // phase sequencer: idle -> low -> high -> idle
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (cmd_req && !sda_lvl) phase <= PH_LOW;
                end
                PH_LOW: begin
                    if (cnt == LAST) begin
                        phase <= PH_HIGH;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cnt == LAST) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // drive outputs from phase state
    always_comb begin
        pull_low = (phase == PH_LOW);
        active   = (phase != PH_IDLE);
    end

    // checker: length of the current pull-low run
    logic [RW-1:0] low_run;
    always_ff @(posedge clk) begin
        if (!rst_n)        low_run <= '0;
        else if (pull_low) low_run <= low_run + 1'b1;
        else               low_run <= '0;
    end

    // R6
    pull_low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pull_low) && enable |-> low_run == RW'(PHASE_CYC));
    // R10
    pull_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pull_low |-> active);
    // R7
    high_sda_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active && cmd_req && sda_lvl |=> !active);
    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active && !pull_low && enable |=> !pull_low);
endmodule

// File: rtl/bus_busy_recover.sv
// Module: top of the bus occupancy monitor and recovery pulser.
// Synchronises both lines, keeps the busy flag, and presents the
// status/command word. Assumes reg_wr is a single-cycle strobe.
module bus_busy_recover
    import bus_busy_recover_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PHASE_CYC   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sda_in,
    input  logic              scl_in,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              scl_pull_low
);
    logic [1:0] lines_s;
    logic       sda_s, scl_s;
    logic       start_det, stop_det;
    logic       busy_q;
    logic       tgl_active;
    logic       busy_clr, tgl_req;

    bbr_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({scl_in, sda_in}),
        .q_sync  (lines_s)
    );

    assign sda_s = lines_s[0];
    assign scl_s = lines_s[1];

    bbr_cond_detect u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_s     (scl_s),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // decode write strobes into per-bit actions
    always_comb begin
        busy_clr = reg_wr & reg_wdata[BIT_BUSY];
        tgl_req  = reg_wr & reg_wdata[BIT_TGL];
    end

    bbr_pulse_gen #(.PHASE_CYC(PHASE_CYC)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .cmd_req  (tgl_req),
        .sda_lvl  (sda_s),
        .pull_low (scl_pull_low),
        .active   (tgl_active)
    );

    // busy flag: clear has priority over set
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)                 busy_q <= 1'b0;
        else if (stop_det || busy_clr)         busy_q <= 1'b0;
        else if (start_det || !sda_s || !scl_s) busy_q <= 1'b1;
    end

    // assemble status word
    always_comb begin
        reg_rdata           = '0;
        reg_rdata[BIT_BUSY] = busy_q;
        reg_rdata[BIT_SDA]  = sda_s;
        reg_rdata[BIT_TGL]  = tgl_active;
    end

    // R4
    stop_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !busy_q);
    // R3
    low_line_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable && (!sda_s || !scl_s) && !stop_det && !busy_clr |=> busy_q);
    // R9
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !busy_q && !tgl_active && !scl_pull_low);
    // R5
    write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_clr |=> !busy_q);
endmodule

// File: tb/bus_busy_recover_tb.sv
module bus_busy_recover_tb;
    localparam int P = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       sda_drv = 1'b1;
    logic       scl_drv = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       scl_pull_low;
    wire        scl_line = scl_drv & ~scl_pull_low;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    bus_busy_recover #(.SYNC_STAGES(2), .PHASE_CYC(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .sda_in(sda_drv), .scl_in(scl_line),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .scl_pull_low(scl_pull_low)
    );

    // ---------------- behavioural reference model ----------------
    bit q_sda[$] = '{1'b1, 1'b1};
    bit q_scl[$] = '{1'b1, 1'b1};
    bit m_psda = 1'b1, m_pscl = 1'b1, m_busy = 1'b0;
    int m_left = 0;

    always @(posedge clk) begin
        bit cs, cl, st, sp, line_in;
        if (!rst_n) begin
            q_sda = '{1'b1, 1'b1};
            q_scl = '{1'b1, 1'b1};
            m_psda = 1'b1; m_pscl = 1'b1; m_busy = 1'b0; m_left = 0;
        end else begin
            line_in = scl_drv & !(m_left > P);
            cs = q_sda[0]; cl = q_scl[0];
            st = m_pscl && cl && m_psda && !cs;
            sp = m_pscl && cl && !m_psda && cs;
            m_psda = cs; m_pscl = cl;
            if (!enable) m_busy = 1'b0;
            else if (sp || (reg_wr && reg_wdata[0])) m_busy = 1'b0;
            else if (st || !cs || !cl) m_busy = 1'b1;
            if (!enable) m_left = 0;
            else if (m_left > 0) m_left = m_left - 1;
            else if (reg_wr && reg_wdata[2] && !cs) m_left = 2 * P;
            q_sda.push_back(sda_drv); void'(q_sda.pop_front());
            q_scl.push_back(line_in); void'(q_scl.pop_front());
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(reg_rdata[0] == m_busy, "R3", reg_rdata[0], m_busy);
            check(reg_rdata[1] == q_sda[0], "R2", reg_rdata[1], q_sda[0]);
            check(reg_rdata[2] == (m_left > 0), "R6", reg_rdata[2], m_left > 0);
            check(scl_pull_low == (m_left > P), "R6", scl_pull_low, m_left > P);
            check(reg_rdata[7:3] == 5'b0, "R1", reg_rdata[7:3], 0);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_word(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int lows, acts;
        wait_n(3);
        rst_n = 1'b1; enable = 1'b1;
        wait_n(3);
        // R1: reset state
        check(reg_rdata == 8'h02, "R1", reg_rdata, 8'h02);
        check(scl_pull_low == 1'b0, "R1", scl_pull_low, 0);

        // R3: Start condition sets busy
        sda_drv = 1'b0; wait_n(4);
        check(reg_rdata[0] == 1'b1, "R3", reg_rdata[0], 1);
        check(reg_rdata[1] == 1'b0, "R2", reg_rdata[1], 0);
        scl_drv = 1'b0; wait_n(4);
        scl_drv = 1'b1; wait_n(4);
        // R4: Stop clears busy
        sda_drv = 1'b1; wait_n(4);
        check(reg_rdata[0] == 1'b0, "R4", reg_rdata[0], 0);

        // R3: clock low alone sets busy, no stop follows
        scl_drv = 1'b0; wait_n(4);
        scl_drv = 1'b1; wait_n(4);
        check(reg_rdata[0] == 1'b1, "R3", reg_rdata[0], 1);
        // R5: write 0 keeps, write 1 clears
        write_word(8'h00);
        check(reg_rdata[0] == 1'b1, "R5", reg_rdata[0], 1);
        write_word(8'h01);
        check(reg_rdata[0] == 1'b0, "R5", reg_rdata[0], 0);

        // stuck data line; R2 write to level bit ignored
        sda_drv = 1'b0; wait_n(4);
        write_word(8'h02);
        check(reg_rdata[1] == 1'b0, "R2", reg_rdata[1], 0);

        // R6 / R8: recovery pulse with a second command mid-pulse
        @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h04;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = 8'h00;
        check(scl_pull_low == 1'b1, "R6", scl_pull_low, 1);
        lows = 0; acts = 0;
        for (int i = 0; i < 2 * P + 6; i++) begin
            lows += scl_pull_low;
            acts += reg_rdata[2];
            if (i == 2) begin reg_wr = 1'b1; reg_wdata = 8'h04; end
            if (i == 3) begin reg_wr = 1'b0; reg_wdata = 8'h00; end
            @(negedge clk);
        end
        check(lows == P, "R6", lows, P);
        check(acts == 2 * P, "R8", acts, 2 * P);

        // R4: slave releases data while clock high -> Stop
        sda_drv = 1'b1; wait_n(4);
        check(reg_rdata[0] == 1'b0, "R4", reg_rdata[0], 0);

        // R7: command with data high ignored
        write_word(8'h04);
        acts = 0;
        for (int i = 0; i < 2 * P; i++) begin
            acts += reg_rdata[2] | scl_pull_low;
            @(negedge clk);
        end
        check(acts == 0, "R7", acts, 0);

        // R9: disable aborts a running pulse
        sda_drv = 1'b0; wait_n(4);
        write_word(8'h04);
        wait_n(2);
        enable = 1'b0;
        @(negedge clk);
        check(scl_pull_low == 1'b0, "R9", scl_pull_low, 0);
        check(reg_rdata[2:0] == 3'b000, "R9", reg_rdata[2:0], 0);
        write_word(8'h04);
        wait_n(2);
        check(reg_rdata[2] == 1'b0, "R9", reg_rdata[2], 0);
        sda_drv = 1'b1; wait_n(3);
        check(reg_rdata[1] == 1'b1, "R2", reg_rdata[1], 1);
        enable = 1'b1; wait_n(4);
        check(reg_rdata == 8'h02, "R10", reg_rdata, 8'h02);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule